// File: doc/BRIEF.md
# Debug Port Control and Status Register

This block is the 32-bit control/status word of a debug port. It drives three request lines towards the power and reset controllers and reports their acknowledges back. It keeps three flags that can only be cleared by writing a 1: access error, compare hit and overrun. It also holds the transfer mode, a byte-lane mask and a transaction counter. Writes and reads come from the scan-access logic over a plain register port. The read word is combinational from the stored state.

Access-port requests pass through this block. The block forwards a request unless one is already outstanding or an error or overrun flag is set. In normal mode the read data returned by the access port goes back to the scan side. In the two pushed modes no data is returned. Instead, the returned word is compared with the word supplied at request time, under the byte-lane mask. The result sets the compare flag: on equality in compare mode, on difference in verify mode.

Top module: `dp_ctrl_stat`

## Requirements
- R1: After reset the read word is 0x00000000 while all acknowledge inputs are low, and no request is forwarded.
- R2: Bits 30, 28 and 26 are writable request bits that drive the system power, debug power and debug reset request outputs. Bits 31, 29 and 27 show the matching acknowledge inputs after SYNC_STAGES clocks, and writes to them have no effect.
- R3: Bits 25:22 and 7:6 always read as zero.
- R4: Writing 1 to bit 5, 4 or 1 clears that flag, and writing 0 leaves it unchanged. A set event in the same cycle as a clearing write leaves the flag at 1.
- R5: A completion with the error input high sets bit 5.
- R6: A request is forwarded only when none is outstanding. A request that arrives while one is outstanding sets bit 1 only if bit 0 is 1.
- R7: While bit 5 or bit 1 is 1, no request is forwarded.
- R8: With bits 3:2 = 10 (compare), an error-free completion whose masked data equals the masked request word sets bit 4.
- R9: With bits 3:2 = 01 (verify), an error-free completion whose masked data differs from the masked request word sets bit 4, and a match leaves it clear.
- R10: Bits 11:8 select byte lanes 3..0 for the comparison. The values 0000 and 1111 both compare all 32 bits.
- R11: With bits 3:2 = 00 or 11, an error-free completion returns its data with a response-valid strobe and leaves bit 4 untouched. In the pushed modes no response is returned.
- R12: Bits 21:12 hold a counter. It decrements on each error-free completion when it is non-zero and holds at zero. A register write in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Current register read value |
| sys_pwr_ack_i | input | 1 | System power-up acknowledge |
| dbg_pwr_ack_i | input | 1 | Debug power-up acknowledge |
| dbg_rst_ack_i | input | 1 | Debug reset acknowledge |
| sys_pwr_req_o | output | 1 | System power-up request |
| dbg_pwr_req_o | output | 1 | Debug power-up request |
| dbg_rst_req_o | output | 1 | Debug reset request |
| ap_req_i | input | 1 | Access request from the scan side |
| ap_req_data_i | input | 32 | Word to compare against in pushed modes |
| ap_issue_o | output | 1 | Request forwarded to the access port |
| ap_pushed_o | output | 1 | Current mode is compare or verify |
| ap_done_i | input | 1 | Access port completion strobe |
| ap_err_i | input | 1 | Completion carried an error |
| ap_rdata_i | input | 32 | Read data returned with completion |
| rsp_valid_o | output | 1 | Read data returned to the scan side |
| rsp_data_o | output | 32 | Returned read data |

## Verification
Two pairs of functions can act in the same cycle. A clearing register write can coincide with a completion that sets the compare flag. A counter write can coincide with the decrement caused by that same completion. The bench provokes both at once: it holds the write strobe and the completion strobe high across a single clock edge. Afterwards it reads the whole word back and expects the flag still set and the counter equal to the written value. Request forwarding is also tested against an outstanding transfer and against each blocking flag, with the forward strobe sampled in the cycle the request is presented.

// File: rtl/dbg_cs_pkg.sv
package dbg_cs_pkg;
   typedef enum logic [1:0] {
      XM_NORMAL  = 2'b00,
      XM_VERIFY  = 2'b01,
      XM_COMPARE = 2'b10,
      XM_SPARE   = 2'b11
   } xfer_mode_e;

   localparam int B_ORUN_EN = 0;
   localparam int B_ORUN    = 1;
   localparam int B_MODE_LO = 2;
   localparam int B_CMP     = 4;
   localparam int B_ERR     = 5;
   localparam int B_MASK_LO = 8;
   localparam int B_CNT_LO  = 12;
   localparam int CNT_FIELD = 10;
   localparam int B_RST_REQ = 26;
   localparam int B_RST_ACK = 27;
   localparam int B_DBG_REQ = 28;
   localparam int B_DBG_ACK = 29;
   localparam int B_SYS_REQ = 30;
   localparam int B_SYS_ACK = 31;
endpackage

// File: rtl/cs_ack_sync.sv
module cs_ack_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cs_sticky_bit.sv
module cs_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end

   // R4: a set event is never lost to a clearing write
   p_set_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q);
   // R4: a clearing write without a set event empties the flag
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q);
endmodule

// File: rtl/cs_lane_match.sv
module cs_lane_match #(
   parameter int LANES = 4
) (
   input  logic [8*LANES-1:0] a_i,
   input  logic [8*LANES-1:0] b_i,
   input  logic [LANES-1:0]   lane_sel_i,
   output logic               same_o
);
   logic             full_word;
   logic [LANES-1:0] lane_ok;

   assign full_word = (lane_sel_i == '0) || (lane_sel_i == '1);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane_ok[g] = (a_i[g*8 +: 8] == b_i[g*8 +: 8]) ||
                             !(full_word || lane_sel_i[g]);
      end
   endgenerate

   assign same_o = &lane_ok;
endmodule

// File: rtl/cs_txn_tracker.sv
module cs_txn_tracker #(
   parameter int CNT_W  = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [DATA_W-1:0] req_data_i,
   input  logic              blocked_i,
   input  logic              done_i,
   input  logic              err_i,
   input  logic              cnt_wr_i,
   input  logic [CNT_W-1:0]  cnt_wdata_i,
   output logic              issue_o,
   output logic              pending_o,
   output logic              collide_o,
   output logic [DATA_W-1:0] cmp_word_o,
   output logic [CNT_W-1:0]  cnt_o
);
   logic              pend_q;
   logic [DATA_W-1:0] word_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              done_ok;

   assign issue_o   = req_i && !pend_q && !blocked_i;
   assign collide_o = req_i && pend_q;
   assign done_ok   = done_i && !err_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         word_q <= '0;
      end else if (issue_o) begin
         pend_q <= 1'b1;
         word_q <= req_data_i;
      end else if (done_i) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (cnt_wr_i)               cnt_q <= cnt_wdata_i;
      else if (done_ok && cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
   end

   assign pending_o  = pend_q;
   assign cmp_word_o = word_q;
   assign cnt_o      = cnt_q;

   // R12: one step down per clean completion, never below zero
   p_cnt_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ok && !cnt_wr_i && cnt_q != 0) |=> (cnt_q == $past(cnt_q) - 1'b1));
   p_cnt_floor_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr_i && cnt_q == 0) |=> (cnt_q == 0));
endmodule

// File: rtl/dp_ctrl_stat.sv
module dp_ctrl_stat
   import dbg_cs_pkg::*;
#(
   parameter int LANES       = 4,
   parameter int CNT_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                csr_we,
   input  logic [31:0]         csr_wdata,
   output logic [31:0]         csr_rdata,
   input  logic                sys_pwr_ack_i,
   input  logic                dbg_pwr_ack_i,
   input  logic                dbg_rst_ack_i,
   output logic                sys_pwr_req_o,
   output logic                dbg_pwr_req_o,
   output logic                dbg_rst_req_o,
   input  logic                ap_req_i,
   input  logic [8*LANES-1:0]  ap_req_data_i,
   output logic                ap_issue_o,
   output logic                ap_pushed_o,
   input  logic                ap_done_i,
   input  logic                ap_err_i,
   input  logic [8*LANES-1:0]  ap_rdata_i,
   output logic                rsp_valid_o,
   output logic [8*LANES-1:0]  rsp_data_o
);
   localparam int DATA_W = 8 * LANES;

   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("dp_ctrl_stat: register layout needs LANES == 4");
      end
      if (CNT_W < 1 || CNT_W > CNT_FIELD) begin : g_bad_cnt
         $error("dp_ctrl_stat: CNT_W must be 1..10");
      end
   endgenerate

   // Plain read/write fields
   logic [2:0]       req_q;      // {sys, dbg, rst}
   logic             orun_en_q;
   xfer_mode_e       mode_q;
   logic [LANES-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q     <= '0;
         orun_en_q <= 1'b0;
         mode_q    <= XM_NORMAL;
         mask_q    <= '0;
      end else if (csr_we) begin
         req_q     <= {csr_wdata[B_SYS_REQ], csr_wdata[B_DBG_REQ], csr_wdata[B_RST_REQ]};
         orun_en_q <= csr_wdata[B_ORUN_EN];
         mode_q    <= xfer_mode_e'(csr_wdata[B_MODE_LO +: 2]);
         mask_q    <= csr_wdata[B_MASK_LO +: LANES];
      end
   end

   // Acknowledges from other controllers
   logic [2:0] ack_s;
   cs_ack_sync #(.W(3), .STAGES(SYNC_STAGES)) i_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sys_pwr_ack_i, dbg_pwr_ack_i, dbg_rst_ack_i}),
      .q     (ack_s)
   );

   // Mode decode
   logic is_cmp, is_ver, pushed;
   assign is_cmp = (mode_q == XM_COMPARE);
   assign is_ver = (mode_q == XM_VERIFY);
   assign pushed = is_cmp || is_ver;

   // Transaction tracking and counter
   logic              f_err, f_cmp, f_orun;
   logic              blocked, pending, collide;
   logic [DATA_W-1:0] cmp_word;
   logic [CNT_W-1:0]  cnt;

   assign blocked = f_err || f_orun;

   cs_txn_tracker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (ap_req_i),
      .req_data_i  (ap_req_data_i),
      .blocked_i   (blocked),
      .done_i      (ap_done_i),
      .err_i       (ap_err_i),
      .cnt_wr_i    (csr_we),
      .cnt_wdata_i (csr_wdata[B_CNT_LO +: CNT_W]),
      .issue_o     (ap_issue_o),
      .pending_o   (pending),
      .collide_o   (collide),
      .cmp_word_o  (cmp_word),
      .cnt_o       (cnt)
   );

   // Masked comparison
   logic same;
   cs_lane_match #(.LANES(LANES)) i_match (
      .a_i        (ap_rdata_i),
      .b_i        (cmp_word),
      .lane_sel_i (mask_q),
      .same_o     (same)
   );

   // Write-one-to-clear flags
   logic set_err, set_cmp, set_orun;
   assign set_err  = ap_done_i && ap_err_i;
   assign set_cmp  = ap_done_i && !ap_err_i && ((is_cmp && same) || (is_ver && !same));
   assign set_orun = collide && orun_en_q;

   cs_sticky_bit i_flag_err (
      .clk(clk), .rst_n(rst_n), .set_i(set_err),
      .clr_i(csr_we && csr_wdata[B_ERR]), .q(f_err));
   cs_sticky_bit i_flag_cmp (
      .clk(clk), .rst_n(rst_n), .set_i(set_cmp),
      .clr_i(csr_we && csr_wdata[B_CMP]), .q(f_cmp));
   cs_sticky_bit i_flag_orun (
      .clk(clk), .rst_n(rst_n), .set_i(set_orun),
      .clr_i(csr_we && csr_wdata[B_ORUN]), .q(f_orun));

   // Response path
   assign rsp_valid_o = ap_done_i && !ap_err_i && !pushed;
   assign rsp_data_o  = ap_rdata_i;
   assign ap_pushed_o = pushed;

   assign sys_pwr_req_o = req_q[2];
   assign dbg_pwr_req_o = req_q[1];
   assign dbg_rst_req_o = req_q[0];

   // Read word assembly
   always_comb begin
      csr_rdata                        = '0;
      csr_rdata[B_SYS_ACK]             = ack_s[2];
      csr_rdata[B_SYS_REQ]             = req_q[2];
      csr_rdata[B_DBG_ACK]             = ack_s[1];
      csr_rdata[B_DBG_REQ]             = req_q[1];
      csr_rdata[B_RST_ACK]             = ack_s[0];
      csr_rdata[B_RST_REQ]             = req_q[0];
      csr_rdata[B_CNT_LO +: CNT_W]     = cnt;
      csr_rdata[B_MASK_LO +: LANES]    = mask_q;
      csr_rdata[B_ERR]                 = f_err;
      csr_rdata[B_CMP]                 = f_cmp;
      csr_rdata[B_MODE_LO +: 2]        = mode_q;
      csr_rdata[B_ORUN]                = f_orun;
      csr_rdata[B_ORUN_EN]             = orun_en_q;
   end

   logic wdata_unused;
   assign wdata_unused = ^{csr_wdata[B_SYS_ACK], csr_wdata[B_DBG_ACK], csr_wdata[B_RST_ACK],
                           csr_wdata[25:22], csr_wdata[7:6], csr_wdata};

   // R7: nothing is forwarded while a blocking flag is up
   p_issue_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ap_issue_o |-> !(csr_rdata[B_ERR] || csr_rdata[B_ORUN]));
   // R6: one outstanding request at most
   p_issue_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ap_issue_o |-> !pending);
   // R6: overrun flag only rises while detection is enabled
   p_orun_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csr_rdata[B_ORUN]) |-> $past(csr_rdata[B_ORUN_EN]));
   // R5: an error completion leaves the error flag set
   p_err_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_done_i && ap_err_i) |=> csr_rdata[B_ERR]);
   // R11: data is handed back only outside the pushed modes
   p_rsp_normal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> !ap_pushed_o);
endmodule

// File: tb/test_dp_ctrl_stat.sv
`timescale 1ns/1ps
module test_dp_ctrl_stat;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        sys_ack = 1'b0, dbg_ack = 1'b0, rst_ack = 1'b0;
   logic        sys_req, dbg_req, rst_req;
   logic        ap_req = 1'b0;
   logic [31:0] ap_req_data = '0;
   logic        ap_issue, ap_pushed;
   logic        ap_done = 1'b0, ap_err = 1'b0;
   logic [31:0] ap_rdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   dp_ctrl_stat i_dp_ctrl_stat (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .sys_pwr_ack_i(sys_ack), .dbg_pwr_ack_i(dbg_ack),
      .dbg_rst_ack_i(rst_ack), .sys_pwr_req_o(sys_req), .dbg_pwr_req_o(dbg_req),
      .dbg_rst_req_o(rst_req), .ap_req_i(ap_req), .ap_req_data_i(ap_req_data),
      .ap_issue_o(ap_issue), .ap_pushed_o(ap_pushed), .ap_done_i(ap_done),
      .ap_err_i(ap_err), .ap_rdata_i(ap_rdata), .rsp_valid_o(rsp_valid),
      .rsp_data_o(rsp_data));

   typedef struct packed {
      logic [2:0]  ack;
      logic [31:0] wd;
      logic [31:0] ex;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{3'b000, 32'h5400_0001, 32'h5400_0001},
      '{3'b111, 32'hFFFF_FFFF, 32'hFC3F_FF0D},
      '{3'b101, 32'hAAAA_AAAA, 32'h882A_AA08},
      '{3'b010, 32'h5555_5555, 32'h7415_5505},
      '{3'b000, 32'h0000_0000, 32'h0000_0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic csr_wr(input logic [31:0] d);
      csr_we = 1'b1; csr_wdata = d;
      @(posedge clk); @(negedge clk);
      csr_we = 1'b0;
   endtask

   task automatic txn(input logic [31:0] cd, input logic [31:0] rd, input logic er,
                      output logic iss, output logic rv, output logic [31:0] rdd);
      ap_req = 1'b1; ap_req_data = cd;
      #1 iss = ap_issue;
      @(posedge clk); @(negedge clk);
      ap_req = 1'b0; ap_done = 1'b1; ap_rdata = rd; ap_err = er;
      #1 rv = rsp_valid; rdd = rsp_data;
      @(posedge clk); @(negedge clk);
      ap_done = 1'b0; ap_err = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic iss, rv;
      logic [31:0] rdd;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 reset word", csr_rdata, 32'h0);
      chk("R1 no forward", {31'b0, ap_issue}, 32'h0);

      // Table walk: field storage, read-only acks, reserved bits
      for (int i = 0; i < 5; i++) begin
         {sys_ack, dbg_ack, rst_ack} = VECS[i].ack;
         csr_wr(VECS[i].wd);
         repeat (3) @(negedge clk);
         chk("R2 read word", csr_rdata, VECS[i].ex);
         chk("R2 req outputs", {29'b0, sys_req, dbg_req, rst_req},
             {29'b0, VECS[i].ex[30], VECS[i].ex[28], VECS[i].ex[26]});
         chk("R3 reserved zero", csr_rdata & 32'h03C0_00C0, 32'h0);
      end

      // R11 / R12: normal mode returns data, counter steps down
      csr_wr(32'h0000_3000);
      txn(32'h0, 32'hCAFE_F00D, 1'b0, iss, rv, rdd);
      chk("R11 rsp valid mode00", {31'b0, rv}, 32'h1);
      chk("R11 rsp data", rdd, 32'hCAFE_F00D);
      chk("R12 counter 3->2", csr_rdata, 32'h0000_2000);
      csr_wr(32'h0000_300C);
      txn(32'h0, 32'h1111_2222, 1'b0, iss, rv, rdd);
      chk("R11 rsp valid mode11", {31'b0, rv}, 32'h1);
      chk("R11 mode11 no flag", csr_rdata, 32'h0000_200C);
      csr_wr(32'h0);
      txn(32'h0, 32'h5, 1'b0, iss, rv, rdd);
      chk("R12 counter holds zero", csr_rdata, 32'h0);

      // R8 / R10: compare mode
      csr_wr(32'h0000_0008);
      txn(32'h1234_5678, 32'h1234_5600, 1'b0, iss, rv, rdd);
      chk("R11 no rsp in compare", {31'b0, rv}, 32'h0);
      chk("R10 full word mismatch", csr_rdata & 32'h10, 32'h0);
      txn(32'h1234_5678, 32'h1234_5678, 1'b0, iss, rv, rdd);
      chk("R8 compare hit", csr_rdata & 32'h10, 32'h10);
      csr_wr(32'h0000_0008);
      chk("R4 write 0 keeps flag", csr_rdata & 32'h10, 32'h10);
      csr_wr(32'h0000_0018);
      chk("R4 write 1 clears", csr_rdata, 32'h0000_0008);
      csr_wr(32'h0000_0108);
      txn(32'h1234_5678, 32'hFFFF_FF78, 1'b0, iss, rv, rdd);
      chk("R10 lane0 only hit", csr_rdata & 32'h10, 32'h10);
      csr_wr(32'h0000_0118);
      txn(32'h1234_5678, 32'h1234_5600, 1'b0, iss, rv, rdd);
      chk("R10 lane0 miss", csr_rdata & 32'h10, 32'h0);
      csr_wr(32'h0000_0F08);
      txn(32'h1234_5678, 32'h1234_5679, 1'b0, iss, rv, rdd);
      chk("R10 mask 1111 full word", csr_rdata & 32'h10, 32'h0);
      txn(32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0, iss, rv, rdd);
      chk("R8 mask 1111 hit", csr_rdata & 32'h10, 32'h10);
      csr_wr(32'h0000_0F18);

      // R9: verify mode
      csr_wr(32'h0000_0004);
      txn(32'h1, 32'h1, 1'b0, iss, rv, rdd);
      chk("R9 verify match no flag", csr_rdata & 32'h10, 32'h0);
      txn(32'h1, 32'h3, 1'b0, iss, rv, rdd);
      chk("R9 verify mismatch flag", csr_rdata & 32'h10, 32'h10);
      chk("R11 no rsp in verify", {31'b0, rv}, 32'h0);
      csr_wr(32'h0000_0014);
      chk("R4 clear after verify", csr_rdata, 32'h0000_0004);

      // R5 / R7: error flag blocks further requests
      csr_wr(32'h0);
      txn(32'h0, 32'h0, 1'b1, iss, rv, rdd);
      chk("R5 error flag", csr_rdata, 32'h0000_0020);
      chk("R5 no rsp on error", {31'b0, rv}, 32'h0);
      ap_req = 1'b1;
      #1 chk("R7 blocked by error", {31'b0, ap_issue}, 32'h0);
      @(posedge clk); @(negedge clk); ap_req = 1'b0;
      csr_wr(32'h0000_0020);
      chk("R4 error cleared", csr_rdata, 32'h0);

      // R6: overrun with detection enabled
      csr_wr(32'h0000_0001);
      ap_req = 1'b1; ap_req_data = 32'h0;
      #1 chk("R6 first forwarded", {31'b0, ap_issue}, 32'h1);
      @(posedge clk); @(negedge clk);
      #1 chk("R6 second held back", {31'b0, ap_issue}, 32'h0);
      @(posedge clk); @(negedge clk); ap_req = 1'b0;
      chk("R6 overrun flag", csr_rdata, 32'h0000_0003);
      ap_done = 1'b1;
      @(posedge clk); @(negedge clk); ap_done = 1'b0;
      ap_req = 1'b1;
      #1 chk("R7 blocked by overrun", {31'b0, ap_issue}, 32'h0);
      ap_req = 1'b0;
      csr_wr(32'h0000_0003);
      chk("R4 overrun cleared", csr_rdata, 32'h0000_0001);

      // R6: overrun with detection disabled
      csr_wr(32'h0);
      ap_req = 1'b1;
      @(posedge clk); @(negedge clk);
      #1 chk("R6 held back no detect", {31'b0, ap_issue}, 32'h0);
      @(posedge clk); @(negedge clk); ap_req = 1'b0;
      chk("R6 no flag when disabled", csr_rdata, 32'h0);
      ap_done = 1'b1;
      @(posedge clk); @(negedge clk); ap_done = 1'b0;

      // R4 / R12: clearing write and counter write meet a compare hit
      csr_wr(32'h0000_5008);
      ap_req = 1'b1; ap_req_data = 32'h55;
      @(posedge clk); @(negedge clk);
      ap_req = 1'b0; ap_done = 1'b1; ap_rdata = 32'h55;
      csr_we = 1'b1; csr_wdata = 32'h0000_7018;
      @(posedge clk); @(negedge clk);
      ap_done = 1'b0; csr_we = 1'b0;
      chk("R4 R12 collision", csr_rdata, 32'h0000_7018);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule